// File: doc/BRIEF.md
# Sleep-State Control Register

This block is a 16-bit power-management control register placed in the low half of one 32-bit slot of an I/O-style register bus. Software stores a 3-bit sleep type and then writes a one-shot trigger bit. On that trigger the block decodes the written type and moves its state machine into the matching sleep state. The state drives four active-low outputs: processor stop-clock, S1, S3 and S5. A single wake input brings the machine back to the running state, which releases every output.

The same register has two other fields. A write-only doorbell bit sends a one-cycle pulse toward firmware. A stored routing bit steers the incoming power-management event lines either to the SCI output or to the SMI output.

The state machine has five states:
- `ST_ON`: running, all outputs high.
- `ST_STOPCLK`: stop-clock asserted.
- `ST_SUSP_RAM`: S1 and S3 asserted.
- `ST_SUSP_DISK`: S1, S3 and S5 asserted.
- `ST_SOFT_OFF`: S1, S3 and S5 asserted.

Its transitions are named as follows:
- `ENTER`: from `ST_ON` to the decoded state, on a trigger write whose type is valid.
- `WAKE`: from any sleep state to `ST_ON`, when `wake_in` is high.
- `HOLD`: every other cycle.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: After reset, all four sleep outputs are high, the register reads 0000_0000h and `fw_release` is low.
- R2: A read of the register slot returns the sleep type in bits 12:10 and the routing bit in bit 0. Every other bit reads 0, including trigger bit 13, doorbell bit 2 and the whole upper 16 bits. A read of any other slot returns 0.
- R3: A write with bit 13 set and bits 12:10 = 001, made from the running state, drives `stpclk_n` low from the next cycle. The other outputs stay high.
- R4: A trigger write with type 101 drives `slp_s1_n` and `slp_s3_n` low from the next cycle. `stpclk_n` and `slp_s5_n` stay high.
- R5: A trigger write with type 110 or 111 drives `slp_s1_n`, `slp_s3_n` and `slp_s5_n` low from the next cycle. `stpclk_n` stays high.
- R6: A trigger write with type 000, 010, 011 or 100 changes no output. The type field is still stored.
- R7: A one-cycle `wake_in` pulse in any sleep state raises all outputs at the next cycle. In the running state `wake_in` has no effect.
- R8: Trigger writes made while asleep do not change the outputs. If a trigger write and `wake_in` fall in the same cycle while asleep, the wake wins and the trigger is dropped.
- R9: A write with bit 2 set makes `fw_release` high for exactly the one cycle after that write.
- R10: With bit 0 = 1, `pm_event` appears on `sci_out` and `smi_out` is 0. With bit 0 = 0, `pm_event` appears on `smi_out` and `sci_out` is 0. The routing is combinational.
- R11: A write to any other slot changes neither the outputs nor the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Slot (32-bit word) address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| wake_in | input | 1 | Wake pulse, returns the block to running |
| pm_event | input | EVT_W | Power-management event lines to be routed |
| sci_out | output | EVT_W | Events routed to SCI |
| smi_out | output | EVT_W | Events routed to SMI |
| stpclk_n | output | 1 | Processor stop-clock, active low |
| slp_s1_n | output | 1 | S1 sleep output, active low |
| slp_s3_n | output | 1 | S3 sleep output, active low |
| slp_s5_n | output | 1 | S5 sleep output, active low |
| fw_release | output | 1 | One-cycle doorbell pulse to firmware |

## Verification
Two pairs of actions can fall in the same cycle.

The first pair is a trigger write and a wake pulse. The bench drives both on the same clock edge while the machine sits in stop-clock. It judges the outcome at the next cycle: all outputs must be high (wake wins), and they must stay high afterwards, because the dropped trigger must not be replayed.

The second pair is a doorbell and a trigger in one write word. The bench checks that the pulse and the S3 outputs appear together in the cycle after that write.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;

    localparam int TYP_W     = 3;
    localparam int TYP_LSB   = 10;
    localparam int TRIG_BIT  = 13;
    localparam int REL_BIT   = 2;
    localparam int ROUTE_BIT = 0;
    localparam int CTRL_W    = 16;
    localparam int BUS_W     = 32;

    typedef enum logic [2:0] {
        ST_ON,
        ST_STOPCLK,
        ST_SUSP_RAM,
        ST_SUSP_DISK,
        ST_SOFT_OFF
    } slp_state_e;

    // Decodes a sleep type into its target state; on and reserved codes map to ST_ON.
    function automatic slp_state_e typ_to_state(input logic [TYP_W-1:0] t);
        slp_state_e s;
        case (t)
            3'b001:  s = ST_STOPCLK;
            3'b101:  s = ST_SUSP_RAM;
            3'b110:  s = ST_SUSP_DISK;
            3'b111:  s = ST_SOFT_OFF;
            default: s = ST_ON;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pm_ctrl_regs.sv
module pm_ctrl_regs
    import pm_sleep_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                trig,
    output logic [TYP_W-1:0]    trig_typ,
    output logic                route_sci,
    output logic                fw_release
);

    logic             hit;
    logic             wr_hit;
    logic [TYP_W-1:0] typ_q;
    logic             route_q;
    logic [CTRL_W-1:0] ctrl_view;
    logic             wdata_unused;

    assign hit      = (bus_addr == REG_ADDR);
    assign wr_hit   = bus_wr && hit;
    assign trig     = wr_hit && bus_wdata[TRIG_BIT];
    assign trig_typ = bus_wdata[TYP_LSB +: TYP_W];
    assign wdata_unused = ^{bus_wdata[BUS_W-1:TRIG_BIT+1], bus_wdata[TYP_LSB-1:REL_BIT+1],
                            bus_wdata[REL_BIT-1:ROUTE_BIT+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            typ_q      <= '0;
            route_q    <= 1'b0;
            fw_release <= 1'b0;
        end else begin
            fw_release <= wr_hit && bus_wdata[REL_BIT];
            if (wr_hit) begin
                typ_q   <= bus_wdata[TYP_LSB +: TYP_W];
                route_q <= bus_wdata[ROUTE_BIT];
            end
        end
    end

    always_comb begin
        ctrl_view                       = '0;
        ctrl_view[TYP_LSB +: TYP_W]     = typ_q;
        ctrl_view[ROUTE_BIT]            = route_q;
        bus_rdata                       = hit ? {{(BUS_W-CTRL_W){1'b0}}, ctrl_view} : '0;
    end

    assign route_sci = route_q;

endmodule

// File: rtl/pm_sleep_fsm.sv
module pm_sleep_fsm
    import pm_sleep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [TYP_W-1:0] trig_typ,
    input  logic             wake_in,
    output logic             stpclk_n,
    output logic             slp_s1_n,
    output logic             slp_s3_n,
    output logic             slp_s5_n
);

    slp_state_e cur, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_ON;
        else        cur <= nxt;
    end

    // ENTER from ST_ON on a valid trigger, WAKE from any sleep state, otherwise HOLD.
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_ON: begin
                if (trig && (typ_to_state(trig_typ) != ST_ON))
                    nxt = typ_to_state(trig_typ);
            end
            ST_STOPCLK, ST_SUSP_RAM, ST_SUSP_DISK, ST_SOFT_OFF: begin
                if (wake_in) nxt = ST_ON;
            end
            default: nxt = ST_ON;
        endcase
    end

    always_comb begin
        stpclk_n = 1'b1;
        slp_s1_n = 1'b1;
        slp_s3_n = 1'b1;
        slp_s5_n = 1'b1;
        unique case (cur)
            ST_ON: ;
            ST_STOPCLK: stpclk_n = 1'b0;
            ST_SUSP_RAM: begin
                slp_s1_n = 1'b0;
                slp_s3_n = 1'b0;
            end
            ST_SUSP_DISK, ST_SOFT_OFF: begin
                slp_s1_n = 1'b0;
                slp_s3_n = 1'b0;
                slp_s5_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pm_event_route.sv
module pm_event_route #(
    parameter int EVT_W = 1
) (
    input  logic             route_sci,
    input  logic [EVT_W-1:0] pm_event,
    output logic [EVT_W-1:0] sci_out,
    output logic [EVT_W-1:0] smi_out
);

    for (genvar g = 0; g < EVT_W; g++) begin : g_lane
        assign sci_out[g] = pm_event[g] &  route_sci;
        assign smi_out[g] = pm_event[g] & ~route_sci;
    end

endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl
    import pm_sleep_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 1,
    parameter int EVT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wake_in,
    input  logic [EVT_W-1:0]  pm_event,
    output logic [EVT_W-1:0]  sci_out,
    output logic [EVT_W-1:0]  smi_out,
    output logic              stpclk_n,
    output logic              slp_s1_n,
    output logic              slp_s3_n,
    output logic              slp_s5_n,
    output logic              fw_release
);

    logic             trig;
    logic [TYP_W-1:0] trig_typ;
    logic             route_sci;

    pm_ctrl_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .trig       (trig),
        .trig_typ   (trig_typ),
        .route_sci  (route_sci),
        .fw_release (fw_release)
    );

    pm_sleep_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .trig_typ (trig_typ),
        .wake_in  (wake_in),
        .stpclk_n (stpclk_n),
        .slp_s1_n (slp_s1_n),
        .slp_s3_n (slp_s3_n),
        .slp_s5_n (slp_s5_n)
    );

    pm_event_route #(.EVT_W(EVT_W)) u_route (
        .route_sci (route_sci),
        .pm_event  (pm_event),
        .sci_out   (sci_out),
        .smi_out   (smi_out)
    );

endmodule

// File: rtl/pm_sleep_ctrl_chk.sv
module pm_sleep_ctrl_chk #(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 1,
    parameter int EVT_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              wake_in,
    input logic [EVT_W-1:0]  pm_event,
    input logic [EVT_W-1:0]  sci_out,
    input logic [EVT_W-1:0]  smi_out,
    input logic              stpclk_n,
    input logic              slp_s1_n,
    input logic              slp_s3_n,
    input logic              slp_s5_n,
    input logic              fw_release
);

    logic awake;
    logic wr_here;
    logic typ_legal;

    assign awake     = stpclk_n && slp_s1_n && slp_s3_n && slp_s5_n;
    assign wr_here   = bus_wr && (bus_addr == REG_ADDR);
    assign typ_legal = (bus_wdata[12:10] == 3'b001) || (bus_wdata[12:10] == 3'b101) ||
                       (bus_wdata[12:10] == 3'b110) || (bus_wdata[12:10] == 3'b111);

    assert_readback_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[31:13] == '0) && (bus_rdata[9:1] == '0));

    assert_s3_needs_s1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !slp_s3_n |-> !slp_s1_n);

    assert_s5_needs_s3_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slp_s5_n |-> !slp_s3_n);

    assert_bad_typ_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && wr_here && bus_wdata[13] && !typ_legal) |=> awake);

    assert_wake_exits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_in && !awake) |=> awake);

    assert_asleep_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!awake && !wake_in) |=> ($stable(stpclk_n) && $stable(slp_s1_n) &&
                                  $stable(slp_s3_n) && $stable(slp_s5_n)));

    assert_release_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_here && bus_wdata[2]) |=> fw_release);

    assert_release_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_here && bus_wdata[2]) |=> !fw_release);

    assert_route_split_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((sci_out & smi_out) == '0) && ((sci_out | smi_out) == pm_event));

endmodule

bind pm_sleep_ctrl pm_sleep_ctrl_chk #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .EVT_W(EVT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .wake_in    (wake_in),
    .pm_event   (pm_event),
    .sci_out    (sci_out),
    .smi_out    (smi_out),
    .stpclk_n   (stpclk_n),
    .slp_s1_n   (slp_s1_n),
    .slp_s3_n   (slp_s3_n),
    .slp_s5_n   (slp_s5_n),
    .fw_release (fw_release)
);

// File: tb/pm_sleep_ctrl_test.sv
module pm_sleep_ctrl_test;

    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] REG_ADDR = 1;
    localparam logic [ADDR_W-1:0] OTHER_ADDR = 2;

    // [19:16] expected {stpclk_n, slp_s1_n, slp_s3_n, slp_s5_n}, [15:0] write data
    localparam logic [19:0] VEC [8] = '{
        {4'b1111, 16'h2001},
        {4'b0111, 16'h2400},
        {4'b1111, 16'hEBFB},
        {4'b1111, 16'h2C00},
        {4'b1111, 16'h3001},
        {4'b1001, 16'h3400},
        {4'b1000, 16'h3801},
        {4'b1000, 16'h3C00}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              wake_in = 1'b0;
    logic [0:0]        pm_event = '0;
    logic [0:0]        sci_out, smi_out;
    logic              stpclk_n, slp_s1_n, slp_s3_n, slp_s5_n, fw_release;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pm_sleep_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .EVT_W(1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_in(wake_in),
        .pm_event(pm_event), .sci_out(sci_out), .smi_out(smi_out),
        .stpclk_n(stpclk_n), .slp_s1_n(slp_s1_n), .slp_s3_n(slp_s3_n),
        .slp_s5_n(slp_s5_n), .fw_release(fw_release)
    );

    function automatic logic [3:0] outs();
        return {stpclk_n, slp_s1_n, slp_s3_n, slp_s5_n};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic wk);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        wake_in   = wk;
        @(negedge clk);
        bus_wr    = 1'b0;
        wake_in   = 1'b0;
        bus_addr  = REG_ADDR;
    endtask

    task automatic wake();
        @(negedge clk);
        wake_in = 1'b1;
        @(negedge clk);
        wake_in = 1'b0;
    endtask

    function automatic logic [31:0] rd_reg();
        return bus_rdata;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        string tag;
        bus_addr = REG_ADDR;
        repeat (3) @(negedge clk);
        chk("R1 outputs", {28'h0, outs()}, 32'hF);
        chk("R1 readback", bus_rdata, 32'h0);
        chk("R1 release", {31'h0, fw_release}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            case (VEC[i][12:10])
                3'b001:         tag = "R3";
                3'b101:         tag = "R4";
                3'b110, 3'b111: tag = "R5";
                default:        tag = "R6";
            endcase
            wr(REG_ADDR, {16'h0, VEC[i][15:0]}, 1'b0);
            chk(tag, {28'h0, outs()}, {28'h0, VEC[i][19:16]});
            #1;
            chk("R2 readback", rd_reg(), {16'h0, VEC[i][15:0] & 16'h1C01});
            wake();
            chk("R7 wake", {28'h0, outs()}, 32'hF);
        end

        // R7: wake while on has no effect
        wake();
        chk("R7 wake while on", {28'h0, outs()}, 32'hF);

        // R8: trigger while asleep ignored
        wr(REG_ADDR, 32'h0000_2400, 1'b0);
        wr(REG_ADDR, 32'h0000_3C00, 1'b0);
        chk("R8 asleep trigger", {28'h0, outs()}, 32'h7);
        // R8: wake and trigger together, wake wins
        wr(REG_ADDR, 32'h0000_3400, 1'b1);
        chk("R8 wake wins", {28'h0, outs()}, 32'hF);
        @(negedge clk);
        chk("R8 trigger dropped", {28'h0, outs()}, 32'hF);

        // R9: doorbell pulse
        wr(REG_ADDR, 32'h0000_0004, 1'b0);
        chk("R9 pulse high", {31'h0, fw_release}, 32'h1);
        #1;
        chk("R9 reads zero", rd_reg(), 32'h0);
        @(negedge clk);
        chk("R9 pulse single", {31'h0, fw_release}, 32'h0);
        // R9 with trigger in the same word
        wr(REG_ADDR, 32'h0000_3404, 1'b0);
        chk("R9 pulse with trigger", {31'h0, fw_release}, 32'h1);
        chk("R4 with doorbell", {28'h0, outs()}, 32'h9);
        wake();

        // R10: routing
        wr(REG_ADDR, 32'h0000_0001, 1'b0);
        pm_event = 1'b1;
        #1;
        chk("R10 sci", {30'h0, sci_out, smi_out}, 32'h2);
        wr(REG_ADDR, 32'h0000_0000, 1'b0);
        #1;
        chk("R10 smi", {30'h0, sci_out, smi_out}, 32'h1);
        pm_event = 1'b0;
        #1;
        chk("R10 idle", {30'h0, sci_out, smi_out}, 32'h0);

        // R11: other slot
        wr(OTHER_ADDR, 32'h0000_3C01, 1'b0);
        chk("R11 outputs", {28'h0, outs()}, 32'hF);
        #1;
        chk("R11 register", rd_reg(), 32'h0);
        bus_addr = OTHER_ADDR;
        #1;
        chk("R2 other slot", bus_rdata, 32'h0);

        // R2: upper and reserved bits
        wr(REG_ADDR, 32'hFFFF_1FFF, 1'b0);
        #1;
        chk("R2 masked", rd_reg(), 32'h0000_1C01);
        chk("R6 no trigger", {28'h0, outs()}, 32'hF);

        summary();
    end

endmodule